// File: doc/BRIEF.md
# System control register bank

This block is a bank of software-visible control words on a plain 32-bit register bus. One bus beat carries a valid strobe, a write flag, a byte address inside a 4 KB window, and write data. Each accepted beat gets a registered response one clock later: read data, a response-valid pulse and an error flag. The lower part of the window holds a parameterised array of full-word registers that software can read and write. A few of these registers come out of reset with non-zero contents. Three of them report two status bits as always set when they are read.

A command word sits in the upper part of the window, outside the storage array. A write there is not stored. Instead, its data is decoded into a one-cycle request to reset the system or to shut it down. The logic that acts on those requests sits outside this block.

Top module: `sysctl_bank`

## Requirements
- R1: The word index is address bits 11:2. Address bits 1:0 are ignored, so an unaligned address reaches the same word as its aligned address (for example 0x023 reaches 0x020, and 0xF02 reaches the command word).
- R2: A valid in-range write replaces the whole 32-bit word. A valid read returns the stored word on `rsp_rdata`, with `rsp_valid` high, on the cycle after the strobe. Every valid beat pulses `rsp_valid` for one cycle.
- R3: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds 0. During reset all outputs are 0.
- R4: A read of word 0x40, 0x42 or 0x43 (byte offsets 0x100, 0x108, 0x10C) returns the stored word with bits 29 and 28 set (OR 0x30000000). The stored word itself is not changed. Word 0x41 and all other words are returned unmodified.
- R5: A read whose word index is 512 or more returns 0 and pulses `rsp_err` together with `rsp_valid`.
- R6: A write whose word index is 512 or more changes no stored word and pulses `rsp_err` together with `rsp_valid`.
- R7: A write of 1 or 2 to the command word (byte offset 0xF00) pulses `sys_reset_req` high for exactly the one cycle after the write.
- R8: A write of 3 to the command word pulses `sys_shutdown_req` high for exactly the one cycle after the write.
- R9: A write of any other value to the command word raises no request. The command word is never stored: a read of it returns 0 and flags `rsp_err`, and every write to it also flags `rsp_err`.
- R10: `sys_reset_req` and `sys_shutdown_req` are never high in the same cycle. Back-to-back command writes give one pulse per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus beat strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse, response to the previous beat |
| rsp_rdata | output | 32 | Registered read data, held between reads |
| rsp_err | output | 1 | Previous beat was outside the storage array |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
Reads of the reset image cover the status words and their neighbour 0x41. This separates words that are forced from words that are not. Writing 0 and 0xCFFFFFFF to a status word shows that the forced bits are added on the read path and never stored. Writes of all ones, alternating bit patterns and zeros, some at unaligned addresses, separate full-word replacement and index decoding from aliasing. On the command word, the bench writes the codes 0 through 4, all ones, an unaligned copy and back-to-back codes. This separates the two request kinds from each other and from no request at all. Out-of-range writes are each followed by a read of the in-range word at the same low index, which shows that nothing wrapped around into storage.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_RESET = 2'd1,
      CMD_SHUT  = 2'd2
   } cmd_e;

   // Power-on image of the storage array, keyed by word index.
   function automatic logic [31:0] init_word(input int idx);
      case (idx)
         'h40:    return 32'h05F2_0121;
         'h41:    return 32'h0000_0002;
         'h42:    return 32'h05F3_0121;
         'h43:    return 32'h05F4_0121;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Words whose readback carries forced status bits.
   function automatic logic is_status_word(input int idx);
      return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
   endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 512,
   parameter int SIDX_W    = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SIDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [NUM_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            mem[i] <= DATA_W'(init_word(i));
         end
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];

   // R2: an accepted write is present in the array on the next cycle
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
   import sysctl_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] CODE_RST_A = DATA_W'(1),
   parameter logic [DATA_W-1:0] CODE_RST_B = DATA_W'(2),
   parameter logic [DATA_W-1:0] CODE_SHUT  = DATA_W'(3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] data,
   output logic              reset_req,
   output logic              shut_req
);

   if (CODE_SHUT == CODE_RST_A || CODE_SHUT == CODE_RST_B) begin : g_bad_codes
      $error("sysctl_cmd: shutdown code overlaps a reset code");
   end

   cmd_e nxt;
   logic is_rst_code, is_shut_code;

   assign is_rst_code  = (data == CODE_RST_A) || (data == CODE_RST_B);
   assign is_shut_code = (data == CODE_SHUT);

   always_comb begin
      nxt = CMD_IDLE;
      if (hit) begin
         if (is_rst_code)       nxt = CMD_RESET;
         else if (is_shut_code) nxt = CMD_SHUT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_req <= 1'b0;
         shut_req  <= 1'b0;
      end else begin
         reset_req <= (nxt == CMD_RESET);
         shut_req  <= (nxt == CMD_SHUT);
      end
   end

   assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reset_req && shut_req));

   assert_reset_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(hit && (data == CODE_RST_A || data == CODE_RST_B)));

   assert_shut_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shut_req |-> $past(hit && data == CODE_SHUT));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!hit) |-> (!reset_req && !shut_req));

endmodule

// File: rtl/sysctl_readback.sv
module sysctl_readback
   import sysctl_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                SIDX_W     = 9,
   parameter bit                FORCE_EN   = 1'b1,
   parameter logic [DATA_W-1:0] FORCE_MASK = DATA_W'(32'h3000_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              is_read,
   input  logic              in_range,
   input  logic [SIDX_W-1:0] idx,
   input  logic [DATA_W-1:0] store_data,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [DATA_W-1:0] ovr;
   logic              status_hit;

   assign status_hit = in_range && is_status_word(int'(idx));

   if (FORCE_EN) begin : g_force
      assign ovr = status_hit ? FORCE_MASK : '0;

      // R4: reads of status words come back with the forced bits set
      assert_force_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && $past(acc && is_read && status_hit))
            |-> ((rsp_rdata & FORCE_MASK) == FORCE_MASK));
   end else begin : g_plain
      assign ovr = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc;
         rsp_err   <= acc && !in_range;
         if (acc && is_read) begin
            rsp_rdata <= in_range ? (store_data | ovr) : '0;
         end
      end
   end

   assert_oor_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(is_read && !in_range)) |-> (rsp_rdata == '0));

   assert_err_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && $past(acc && !in_range)));

   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(acc));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
   import sysctl_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                DATA_W     = 32,
   parameter int                NUM_WORDS  = 512,
   parameter int                CMD_OFFSET = 'hF00,
   parameter bit                FORCE_EN   = 1'b1,
   parameter logic [DATA_W-1:0] FORCE_MASK = DATA_W'(32'h3000_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              sys_reset_req,
   output logic              sys_shutdown_req
);

   localparam int LSB     = 2;
   localparam int IDX_W   = ADDR_W - LSB;
   localparam int SIDX_W  = $clog2(NUM_WORDS);
   localparam int CMD_IDX = CMD_OFFSET >> LSB;

   if (DATA_W > 32 || DATA_W < 30) begin : g_bad_width
      $error("sysctl_bank: word width must lie between 30 and 32 bits");
   end
   if (NUM_WORDS > (1 << IDX_W) || SIDX_W > IDX_W) begin : g_bad_depth
      $error("sysctl_bank: storage array exceeds the window");
   end
   if (CMD_IDX < NUM_WORDS || CMD_IDX >= (1 << IDX_W)) begin : g_bad_cmd
      $error("sysctl_bank: command word must lie in the window above storage");
   end

   logic [IDX_W-1:0]  idx;
   logic [SIDX_W-1:0] sidx;
   logic              in_range;
   logic              wr_store;
   logic              cmd_hit;
   logic [DATA_W-1:0] store_q;
   logic [1:0]        unused_lsb;

   assign unused_lsb = req_addr[LSB-1:0];
   assign idx        = req_addr[ADDR_W-1:LSB];
   assign sidx       = idx[SIDX_W-1:0];
   assign in_range   = ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));
   assign wr_store   = req_valid && req_write && in_range;
   assign cmd_hit    = req_valid && req_write && (idx == IDX_W'(CMD_IDX));

   sysctl_store #(
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS),
      .SIDX_W    (SIDX_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_store),
      .wr_idx  (sidx),
      .wr_data (req_wdata),
      .rd_idx  (sidx),
      .rd_data (store_q)
   );

   sysctl_cmd #(
      .DATA_W (DATA_W)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (cmd_hit),
      .data      (req_wdata),
      .reset_req (sys_reset_req),
      .shut_req  (sys_shutdown_req)
   );

   sysctl_readback #(
      .DATA_W     (DATA_W),
      .SIDX_W     (SIDX_W),
      .FORCE_EN   (FORCE_EN),
      .FORCE_MASK (FORCE_MASK)
   ) u_rdbk (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (req_valid),
      .is_read    (!req_write),
      .in_range   (in_range),
      .idx        (sidx),
      .store_data (store_q),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

   // R9: the command word is never a storage location, so its writes are flagged
   assert_cmd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_hit) |-> rsp_err);

endmodule

// File: tb/tb_sysctl_bank.sv
module tb_sysctl_bank;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [11:0] req_addr;
   logic [31:0] req_wdata;
   logic        rsp_valid, rsp_err, sys_reset_req, sys_shutdown_req;
   logic [31:0] rsp_rdata;

   always #5 clk = ~clk;

   sysctl_bank dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_valid        (req_valid),
      .req_write        (req_write),
      .req_addr         (req_addr),
      .req_wdata        (req_wdata),
      .rsp_valid        (rsp_valid),
      .rsp_rdata        (rsp_rdata),
      .rsp_err          (rsp_err),
      .sys_reset_req    (sys_reset_req),
      .sys_shutdown_req (sys_shutdown_req)
   );

   typedef struct {
      int          stamp;
      bit          chk_rd;
      logic [31:0] rd;
      bit          err;
      bit          rst;
      bit          shd;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   bit          started = 1'b0;
   bit          done = 1'b0;
   logic [31:0] model [512];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, string fld, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
      end
   endtask

   // Driver: computes the expectation from the requirements and drives one beat.
   task automatic access(bit wr, logic [11:0] a, logic [31:0] d, string tag);
      exp_t e;
      int   ix;
      bit   inr, cmd;
      ix  = int'(a[11:2]);
      inr = ix < 512;
      cmd = wr && (ix == 'h3C0);
      e.tag    = tag;
      e.chk_rd = !wr;
      e.err    = !inr;
      e.rst    = cmd && (d == 1 || d == 2);
      e.shd    = cmd && (d == 3);
      e.rd     = '0;
      if (!wr && inr) begin
         e.rd = model[ix];
         if (ix == 'h40 || ix == 'h42 || ix == 'h43) e.rd = e.rd | 32'h3000_0000;
      end
      if (wr && inr) model[ix] = d;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      e.stamp   = cyc;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_write = 1'b0;
         req_wdata = 32'hDEAD_BEEF;
      end
   endtask

   // Monitor: pops the item issued on the previous cycle and compares.
   always @(negedge clk) begin
      if (started) begin
         if (q.size() > 0 && q[0].stamp == cyc - 1) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "rsp_valid", 32'(rsp_valid), 32'd1);
            check(e.tag, "rsp_err", 32'(rsp_err), 32'(e.err));
            check(e.tag, "sys_reset_req", 32'(sys_reset_req), 32'(e.rst));
            check(e.tag, "sys_shutdown_req", 32'(sys_shutdown_req), 32'(e.shd));
            if (e.chk_rd) check(e.tag, "rsp_rdata", rsp_rdata, e.rd);
         end else begin
            check("R10 idle", "pulses", {29'd0, rsp_valid, sys_reset_req, sys_shutdown_req}, 32'd0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) model[i] = 32'h0;
      model['h40] = 32'h05F2_0121;
      model['h41] = 32'h0000_0002;
      model['h42] = 32'h05F3_0121;
      model['h43] = 32'h05F4_0121;

      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R3 in reset", "outputs",
            {27'd0, rsp_valid, rsp_err, sys_reset_req, sys_shutdown_req, |rsp_rdata}, 32'd0);
      rst_n = 1'b1;
      started = 1'b1;

      // R3 reset image and R4 forced readback, including neighbours
      for (int i = 'h3E; i <= 'h45; i++) access(1'b0, 12'(i * 4), 32'h0, "R3/R4 reset image");
      access(1'b0, 12'h000, 32'h0, "R3 word 0");
      access(1'b0, 12'h7FC, 32'h0, "R3 last word");

      // R2 full-word writes with several patterns
      access(1'b1, 12'h010, 32'hA5A5_5A5A, "R2 write");
      access(1'b1, 12'h7FC, 32'hFFFF_FFFF, "R2 write");
      access(1'b1, 12'h004, 32'h1234_5678, "R2 write");
      access(1'b0, 12'h010, 32'h0, "R2 read alt");
      access(1'b0, 12'h7FC, 32'h0, "R2 read ones");
      access(1'b0, 12'h004, 32'h0, "R2 read");
      access(1'b1, 12'h010, 32'h0, "R2 overwrite");
      access(1'b0, 12'h010, 32'h0, "R2 read zero");

      // R1 unaligned decode
      access(1'b1, 12'h023, 32'hC0DE_0001, "R1 unaligned write");
      access(1'b0, 12'h020, 32'h0, "R1 aligned read");
      access(1'b0, 12'h022, 32'h0, "R1 unaligned read");

      // R4 forced bits added only on readback
      access(1'b1, 12'h100, 32'h0, "R4 write status");
      access(1'b0, 12'h100, 32'h0, "R4 read status");
      access(1'b1, 12'h10C, 32'hCFFF_FFFF, "R4 write status");
      access(1'b0, 12'h10C, 32'h0, "R4 read status");
      access(1'b1, 12'h104, 32'h0, "R4 write plain");
      access(1'b0, 12'h104, 32'h0, "R4 read plain");
      access(1'b0, 12'h10A, 32'h0, "R4 unaligned status");

      // R5 rejected reads
      access(1'b0, 12'h800, 32'h0, "R5 oor read");
      access(1'b0, 12'hFFC, 32'h0, "R5 oor read top");

      // R6 rejected writes leave storage unchanged
      access(1'b1, 12'h804, 32'hBAD0_BAD0, "R6 oor write");
      access(1'b0, 12'h004, 32'h0, "R6 alias unchanged");
      access(1'b1, 12'hFFC, 32'hBAD1_BAD1, "R6 oor write top");
      access(1'b0, 12'h7FC, 32'h0, "R6 alias unchanged");

      // R7, R8, R9 command word
      access(1'b1, 12'hF00, 32'd1, "R7 reset code 1");
      idle(1);
      access(1'b1, 12'hF00, 32'd2, "R7 reset code 2");
      idle(1);
      access(1'b1, 12'hF00, 32'd3, "R8 shutdown code");
      idle(1);
      access(1'b1, 12'hF00, 32'd0, "R9 code 0");
      access(1'b1, 12'hF00, 32'd4, "R9 code 4");
      access(1'b1, 12'hF00, 32'hFFFF_FFFF, "R9 code ones");
      access(1'b0, 12'hF00, 32'h0, "R9 read cmd word");
      access(1'b1, 12'hF02, 32'd3, "R1 unaligned shutdown");
      idle(1);

      // R10 back-to-back command writes
      access(1'b1, 12'hF00, 32'd1, "R10 back-to-back reset");
      access(1'b1, 12'hF00, 32'd3, "R10 back-to-back shutdown");
      access(1'b1, 12'hF00, 32'd2, "R10 back-to-back reset");
      access(1'b1, 12'hF00, 32'd2, "R10 repeat reset");
      idle(1);

      // R4 status word 0x108 reset value untouched by earlier traffic
      access(1'b0, 12'h108, 32'h0, "R4 status reset value");
      idle(4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule